// File: doc/BRIEF.md
# Nibble ALU with BCD Adjust

This block is the arithmetic and logic core of a 4-bit controller. It holds the accumulator and the carry flag. Each cycle in which `exec` is high, it carries out the operation selected by `op` and updates the accumulator and carry as that operation requires. The operand `opnd` comes from data memory or from an immediate field. The block does not fetch operands; the surrounding sequencer supplies them.

The combinational `result` and `carry_next` outputs show what the selected operation produces from the current state. The sequencer writes `result` to memory for the memory-destination logic forms.

The decision outputs give the conditional-branch logic what it tests:
- each accumulator bit;
- an accumulator-is-zero flag;
- the carry flag.

The block supports BCD arithmetic with two decimal corrections, one applied after an addition and one after a subtraction.

Top module: `nibble_alu`

## Requirements
- R1: While `rst_n` is low, the accumulator and carry are cleared to 0.
- R2: Op code 2 (add) and op code 0 (add with carry) compute acc + opnd + cin, with cin = 0 for code 2 and cin = carry for code 0. When `exec` is high, the low 4 bits are written to the accumulator and bit 4 is written to carry on the next rising edge.
- R3: Op code 3 (subtract) and op code 1 (subtract with borrow) compute acc + ~opnd + cin, with cin = 1 for code 3 and cin = carry for code 1. The low 4 bits go to the accumulator and the carry out goes to carry, where carry = 1 means no borrow.
- R4: Op codes 4 (AND), 5 (XOR) and 6 (OR) combine the accumulator with `opnd` and write the result to the accumulator. Carry is left unchanged.
- R5: Op code 7 shifts the accumulator right by one bit, inserting 0 at bit 3. The outgoing bit 0 goes to carry.
- R6: Op code 8 (decimal adjust after add) behaves as follows:
  - If the accumulator is above 9 or carry is set, it adds 6 modulo 16 and sets carry.
  - Otherwise the accumulator and carry are unchanged.
- R7: Op code 9 (decimal adjust after subtract) behaves as follows:
  - If carry is clear, it subtracts 6 modulo 16 and carry stays clear.
  - If carry is set, the accumulator and carry are unchanged.
- R8: Op codes 10, 11 and 12 put `opnd` AND, XOR or OR `imm` (respectively) on `result`. The accumulator and carry are unchanged.
- R9: `br_bit[i]` equals accumulator bit i, `br_zero` is high exactly when the accumulator is 0, and `br_carry` equals the carry flag.
- R10: When `exec` is low, or `op` is 13, 14 or 15, the accumulator and carry keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| exec | input | 1 | Perform `op` at this edge |
| op | input | 4 | Operation code |
| opnd | input | 4 | Memory or immediate operand |
| imm | input | 4 | Immediate for memory-destination logic forms |
| result | output | 4 | Combinational operation result |
| carry_next | output | 1 | Carry value the operation would produce |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |
| br_bit | output | 4 | Per-bit test flags |
| br_zero | output | 1 | Accumulator equals zero |
| br_carry | output | 1 | Carry set |

## Verification
The bench targets carry-in selection. A design that used the flag for plain add or subtract, or ignored it for the with-carry forms, would be off by one on every such step.

It drives subtractions that borrow and ones that do not, so that an inverted borrow convention flips the carry. It drives decimal adjusts with the accumulator at 9 and at 10, with carry both set and clear. An off-by-one in the greater-than-9 test, or a correction applied on the wrong carry polarity, would then corrupt BCD digits.

It also checks that the memory-destination logic forms, idle cycles and unused codes leave the accumulator and carry untouched. Finally, it runs an exhaustive add-with-carry plus adjust sweep over all digit pairs.

// File: rtl/nibble_alu.sv
module nibble_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] op,
  input  logic [3:0] opnd,
  input  logic [3:0] imm,
  output logic [3:0] result,
  output logic       carry_next,
  output logic [3:0] acc,
  output logic       carry,
  output logic [3:0] br_bit,
  output logic       br_zero,
  output logic       br_carry
);

  logic       is_sub, cin, writes_acc;
  logic [3:0] bx;
  logic [4:0] sum;

  assign is_sub     = (op == 4'd1) || (op == 4'd3);
  assign bx         = is_sub ? ~opnd : opnd;
  assign cin        = (op == 4'd3) ? 1'b1 : (op == 4'd2) ? 1'b0 : carry;
  assign sum        = {1'b0, acc} + {1'b0, bx} + {4'd0, cin};
  assign writes_acc = (op <= 4'd9);

  always_comb begin
    result     = acc;
    carry_next = carry;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: {carry_next, result} = sum;
      4'd4:  result = acc & opnd;
      4'd5:  result = acc ^ opnd;
      4'd6:  result = acc | opnd;
      4'd7:  {result, carry_next} = {1'b0, acc};
      4'd8:  if (acc > 4'd9 || carry) {carry_next, result} = {1'b1, acc + 4'd6};
      4'd9:  if (!carry) result = acc + 4'd10;
      4'd10: result = opnd & imm;
      4'd11: result = opnd ^ imm;
      4'd12: result = opnd | imm;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= 4'd0;
      carry <= 1'b0;
    end else if (exec && op <= 4'd12) begin
      if (writes_acc) acc <= result;
      carry <= carry_next;
    end
  end

  assign br_bit   = acc;
  assign br_zero  = (acc == 4'd0);
  assign br_carry = carry;

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [3:0] op,
  input logic [3:0] opnd,
  input logic [3:0] imm,
  input logic [3:0] acc,
  input logic       carry
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc == 4'd0 && !carry));

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd2) |=> {carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(opnd)}));

  assert_logic_keeps_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op >= 4'd4 && op <= 4'd6) |=> $stable(carry));

  assert_shift_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd7) |=> (carry == $past(acc[0]) && !acc[3]));

  assert_das_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd9 && carry) |=> ($stable(acc) && carry));

  assert_mem_form_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op >= 4'd10 && op <= 4'd12) |=> ($stable(acc) && $stable(carry)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec || op >= 4'd13) |=> ($stable(acc) && $stable(carry)));

endmodule

bind nibble_alu nibble_alu_chk u_chk (.*);

// File: tb/test_nibble_alu.sv
module test_nibble_alu;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0;
  logic [3:0] op = '0, opnd = '0, imm = '0;
  logic [3:0] result, acc, br_bit;
  logic carry_next, carry, br_zero, br_carry;

  nibble_alu i_nibble_alu (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string      tag;
    logic       chk_res;
    logic [3:0] res;
    logic       cn;
    logic [3:0] acc;
    logic       cy;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [3:0] m_acc = '0;
  logic m_cy = 1'b0;
  logic done = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic [3:0] o, a, b, i, input logic c);
    logic [4:0] s;
    case (o)
      4'd0: s = {1'b0, a} + {1'b0, b} + {4'd0, c};
      4'd1: s = {1'b0, a} + {1'b0, ~b} + {4'd0, c};
      4'd2: s = {1'b0, a} + {1'b0, b};
      4'd3: s = {1'b0, a} + {1'b0, ~b} + 5'd1;
      4'd4: s = {c, a & b};
      4'd5: s = {c, a ^ b};
      4'd6: s = {c, a | b};
      4'd7: s = {a[0], 1'b0, a[3:1]};
      4'd8: s = (a > 4'd9 || c) ? {1'b1, 4'(a + 4'd6)} : {c, a};
      4'd9: s = c ? {c, a} : {1'b0, 4'(a - 4'd6)};
      4'd10: s = {c, b & i};
      4'd11: s = {c, b ^ i};
      4'd12: s = {c, b | i};
      default: s = {c, a};
    endcase
    return s;
  endfunction

  task automatic do_op(input logic [3:0] o, b, i, input string tag, input logic en = 1'b1);
    item_t it;
    logic [4:0] s;
    @(negedge clk);
    exec = en; op = o; opnd = b; imm = i;
    s = model(o, m_acc, b, i, m_cy);
    it.tag = tag;
    it.chk_res = en;
    it.res = s[3:0];
    it.cn = s[4];
    if (en && o <= 4'd12) begin
      if (o <= 4'd9) m_acc = s[3:0];
      m_cy = s[4];
    end
    it.acc = m_acc;
    it.cy = m_cy;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk_res) begin
          chk(result == it.res, it.tag, "result", {1'b0, result}, {1'b0, it.res});
          chk(carry_next == it.cn, it.tag, "carry_next", {4'd0, carry_next}, {4'd0, it.cn});
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(acc == it.acc, it.tag, "acc", {1'b0, acc}, {1'b0, it.acc});
        chk(carry == it.cy, it.tag, "carry", {4'd0, carry}, {4'd0, it.cy});
        chk(br_bit == it.acc && br_zero == (it.acc == 0) && br_carry == it.cy, "R9",
            "flags", {br_zero, br_bit}, {it.acc == 0, it.acc});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    chk(acc == 0 && carry == 0, "R1", "reset state", {carry, acc}, 5'd0);
    chk(br_zero == 1'b1 && br_carry == 1'b0, "R9", "reset flags", {br_carry, 3'd0, br_zero}, 5'd1);
    @(negedge clk); rst_n = 1'b1;
    do_op(4'd2, 4'd7, 4'd0, "R2");
    do_op(4'd2, 4'd9, 4'd0, "R2");
    do_op(4'd0, 4'd5, 4'd0, "R2");
    do_op(4'd3, 4'd8, 4'd0, "R3");
    do_op(4'd1, 4'd3, 4'd0, "R3");
    do_op(4'd9, 4'd0, 4'd0, "R7");
    do_op(4'd8, 4'd0, 4'd0, "R6");
    do_op(4'd8, 4'd0, 4'd0, "R6");
    do_op(4'd3, 4'd6, 4'd0, "R3");
    do_op(4'd5, 4'hF, 4'd0, "R4");
    do_op(4'd4, 4'h5, 4'd0, "R4");
    do_op(4'd6, 4'hA, 4'd0, "R4");
    do_op(4'd7, 4'd0, 4'd0, "R5");
    do_op(4'd7, 4'd0, 4'd0, "R5");
    do_op(4'd7, 4'd0, 4'd0, "R5");
    do_op(4'd10, 4'hC, 4'hA, "R8");
    do_op(4'd11, 4'hC, 4'hA, "R8");
    do_op(4'd12, 4'hC, 4'hA, "R8");
    do_op(4'd13, 4'h9, 4'd0, "R10");
    do_op(4'd15, 4'h9, 4'd0, "R10");
    do_op(4'd2, 4'h9, 4'd0, "R10", 1'b0);
    do_op(4'd8, 4'h0, 4'd0, "R10", 1'b0);
    do_op(4'd4, 4'd0, 4'd0, "R4");
    do_op(4'd6, 4'd3, 4'd0, "R4");
    do_op(4'd3, 4'd4, 4'd0, "R3");
    do_op(4'd9, 4'd0, 4'd0, "R7");
    do_op(4'd8, 4'd0, 4'd0, "R6");
    do_op(4'd3, 4'd0, 4'd0, "R3");
    do_op(4'd6, 4'hA, 4'd0, "R4");
    do_op(4'd8, 4'd0, 4'd0, "R6");
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++) begin
        do_op(4'd4, 4'd0, 4'd0, "R4");
        do_op(4'd6, 4'(a), 4'd0, "R4");
        do_op(4'd0, 4'(b), 4'd0, "R2");
        do_op(4'd8, 4'd0, 4'd0, "R6");
        do_op(4'd1, 4'(a), 4'd0, "R3");
        do_op(4'd9, 4'd0, 4'd0, "R7");
      end
    @(negedge clk); exec = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule